// File: doc/BRIEF.md
# Multi-cycle integer quotient unit

This unit computes 32-bit integer quotients for a processor's execute stage, one bit per clock. The issuing logic presents a dividend, a divisor, a signed/unsigned select and a destination register index together with a one-cycle start pulse. The unit accepts the pulse only when it is idle. It then runs a fixed sequence of iterations plus a final sign-correction cycle. When the result is ready it raises a one-cycle completion pulse, together with a register-file write enable.

The unit never raises a fault. A divisor of zero is replaced by one, so the dividend comes back unchanged. The one signed case whose true quotient does not fit, the most negative value divided by minus one, is also computed as a division by one. Signed operation works on magnitudes and negates the quotient when the operand signs differ, so signed results round toward zero. The iteration step can be built as a restoring or as a non-restoring stage through a parameter, and both give identical quotients.

Top module: `iter_divider`

## Requirements
- R1: In unsigned mode (`is_signed`=0) both operands are unsigned 32-bit values and `quotient` is floor(dividend / divisor).
- R2: In unsigned mode a divisor of 0 is treated as 1, so `quotient` equals the dividend.
- R3: In signed mode (`is_signed`=1) a divisor of 0 is treated as 1, so `quotient` equals the dividend.
- R4: In signed mode, 0x80000000 divided by 0xFFFFFFFF is computed as division by 1, so `quotient` is 0x80000000.
- R5: In signed mode operands are two's complement and the quotient is truncated toward zero, for every combination of operand signs.
- R6: `wr_en` is high only in the cycle where `done` is high, and only if `dest_idx` captured at start was nonzero; for destination 0 `done` still pulses but `wr_en` stays low.
- R7: `done` is high for exactly one cycle, in the 33rd cycle after the clock edge that accepted `start`.
- R8: A `start` pulse that arrives while an operation is in progress is ignored: the running operation's result and timing are unchanged and no extra `done` follows.
- R9: After reset `quotient` is 0 and `done` and `wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (taken only when idle) |
| is_signed | input | 1 | 1 = two's complement operands, 0 = unsigned |
| dividend | input | 32 | Operand A |
| divisor | input | 32 | Operand B |
| dest_idx | input | 5 | Destination register index; 0 discards the result |
| quotient | output | 32 | Result, valid while `done` is high |
| done | output | 1 | One-cycle completion pulse |
| wr_en | output | 1 | Register-file write request for the result |

## Verification
The embedded properties assume that the operand, mode and destination inputs are meaningful only in the cycle where `start` is accepted. They also assume that nothing outside the unit forces it out of its idle/iterate/fix sequence. The stimulus holds every input stable around each accepted start. It fires a second start in the middle of a running operation, with different operands, to show that the unit keeps its captured copies. Operand patterns cover both zero-divisor cases, the signed overflow pair, all four sign combinations and random values. Back-to-back issues are spaced only by the completion pulse.

// File: rtl/div_pkg.sv
package div_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_ITER = 2'd1,
      SEQ_FIX  = 2'd2
   } seq_state_e;

   typedef enum logic {
      STEP_RESTORE    = 1'b0,
      STEP_NONRESTORE = 1'b1
   } step_kind_e;

endpackage

// File: rtl/div_prep.sv
module div_prep #(
   parameter int DW = 32
) (
   input  logic          sgn,
   input  logic [DW-1:0] op_a,
   input  logic [DW-1:0] op_b,
   output logic [DW-1:0] num_mag,
   output logic [DW-1:0] den_mag,
   output logic          negate
);
   localparam logic [DW-1:0] MOST_NEG = {1'b1, {(DW-1){1'b0}}};
   localparam logic [DW-1:0] ALL_ONES = {DW{1'b1}};
   localparam logic [DW-1:0] UNIT     = {{(DW-1){1'b0}}, 1'b1};

   logic          b_zero;
   logic          ovf_pair;
   logic [DW-1:0] den_fix;
   logic          a_neg;
   logic          b_neg;

   always_comb begin
      b_zero   = (op_b == '0);
      ovf_pair = sgn && (op_a == MOST_NEG) && (op_b == ALL_ONES);
      den_fix  = (b_zero || ovf_pair) ? UNIT : op_b;
      a_neg    = sgn && op_a[DW-1];
      b_neg    = sgn && den_fix[DW-1];
      num_mag  = a_neg ? (~op_a + UNIT) : op_a;
      den_mag  = b_neg ? (~den_fix + UNIT) : den_fix;
      negate   = a_neg ^ b_neg;
   end
endmodule

// File: rtl/div_core.sv
module div_core
   import div_pkg::*;
#(
   parameter int         DW   = 32,
   parameter step_kind_e KIND = STEP_NONRESTORE
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          step,
   input  logic [DW-1:0] num,
   input  logic [DW-1:0] den,
   output logic [DW-1:0] quo
);
   localparam int PW = DW + 2;

   logic [PW-1:0] part_q;
   logic [DW-1:0] den_q;
   logic [DW-1:0] quo_q;
   logic [PW-1:0] shifted;
   logic [PW-1:0] den_ext;
   logic [PW-1:0] part_nxt;
   logic          qbit;

   assign shifted = {part_q[DW:0], quo_q[DW-1]};
   assign den_ext = {2'b00, den_q};

   generate
      if (KIND == STEP_RESTORE) begin : g_restore
         logic [PW-1:0] trial;
         always_comb begin
            trial    = shifted - den_ext;
            qbit     = ~trial[PW-1];
            part_nxt = qbit ? trial : shifted;
         end
      end else begin : g_nonrestore
         always_comb begin
            part_nxt = part_q[PW-1] ? (shifted + den_ext) : (shifted - den_ext);
            qbit     = ~part_nxt[PW-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         part_q <= '0;
         den_q  <= '0;
         quo_q  <= '0;
      end else if (load) begin
         part_q <= '0;
         den_q  <= den;
         quo_q  <= num;
      end else if (step) begin
         part_q <= part_nxt;
         quo_q  <= {quo_q[DW-2:0], qbit};
      end
   end

   assign quo = quo_q;

   AST_DIVISOR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (den_q != '0)); // R2
   AST_DIVISOR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> $stable(den_q)); // R8
endmodule

// File: rtl/div_fixup.sv
module div_fixup #(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fire,
   input  logic          negate,
   input  logic          dst_live,
   input  logic [DW-1:0] raw_quo,
   output logic [DW-1:0] quo_out,
   output logic          done_out,
   output logic          we_out
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         quo_out  <= '0;
         done_out <= 1'b0;
         we_out   <= 1'b0;
      end else begin
         done_out <= fire;
         we_out   <= fire && dst_live;
         if (fire) begin
            quo_out <= negate ? (~raw_quo + {{(DW-1){1'b0}}, 1'b1}) : raw_quo;
         end
      end
   end

   AST_WRITE_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      we_out |-> done_out); // R6
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_out |=> !done_out); // R7
endmodule

// File: rtl/iter_divider.sv
module iter_divider
   import div_pkg::*;
#(
   parameter int         DW   = 32,
   parameter int         IW   = 5,
   parameter step_kind_e KIND = STEP_NONRESTORE
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          is_signed,
   input  logic [31:0]   dividend,
   input  logic [31:0]   divisor,
   input  logic [4:0]    dest_idx,
   output logic [31:0]   quotient,
   output logic          done,
   output logic          wr_en
);
   localparam int            CW   = $clog2(DW);
   localparam logic [CW-1:0] LAST = CW'(DW - 1);

   generate
      if (DW != 32) begin : g_bad_width
         $error("iter_divider: data width must match the 32-bit ports");
      end
      if (IW != 5) begin : g_bad_index
         $error("iter_divider: index width must match the 5-bit port");
      end
   endgenerate

   seq_state_e    state_q;
   logic [CW-1:0] iter_q;
   logic          neg_q;
   logic          dst_live_q;
   logic          accept;
   logic          stepping;
   logic          fire;
   logic [DW-1:0] num_mag;
   logic [DW-1:0] den_mag;
   logic          negate;
   logic [DW-1:0] raw_quo;

   assign accept   = start && (state_q == SEQ_IDLE);
   assign stepping = (state_q == SEQ_ITER);
   assign fire     = (state_q == SEQ_FIX);

   div_prep #(.DW(DW)) u_prep (
      .sgn     (is_signed),
      .op_a    (dividend),
      .op_b    (divisor),
      .num_mag (num_mag),
      .den_mag (den_mag),
      .negate  (negate)
   );

   div_core #(.DW(DW), .KIND(KIND)) u_core (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (accept),
      .step  (stepping),
      .num   (num_mag),
      .den   (den_mag),
      .quo   (raw_quo)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= SEQ_IDLE;
         iter_q     <= '0;
         neg_q      <= 1'b0;
         dst_live_q <= 1'b0;
      end else begin
         unique case (state_q)
            SEQ_IDLE: begin
               if (start) begin
                  state_q    <= SEQ_ITER;
                  iter_q     <= '0;
                  neg_q      <= negate;
                  dst_live_q <= (dest_idx != '0);
               end
            end
            SEQ_ITER: begin
               iter_q <= iter_q + 1'b1;
               if (iter_q == LAST) state_q <= SEQ_FIX;
            end
            SEQ_FIX:  state_q <= SEQ_IDLE;
            default:  state_q <= SEQ_IDLE;
         endcase
      end
   end

   div_fixup #(.DW(DW)) u_fix (
      .clk      (clk),
      .rst_n    (rst_n),
      .fire     (fire),
      .negate   (neg_q),
      .dst_live (dst_live_q),
      .raw_quo  (raw_quo),
      .quo_out  (quotient),
      .done_out (done),
      .we_out   (wr_en)
   );

   AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
      (start && state_q != SEQ_IDLE) |=> ($stable(neg_q) && $stable(dst_live_q))); // R8
   AST_R0_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !dst_live_q) |=> (done && !wr_en)); // R6
   AST_FIX_GIVES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> done); // R7
   AST_DONE_FROM_FIX: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(fire)); // R7
endmodule

// File: tb/iter_divider_test.sv
module iter_divider_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        is_signed = 1'b0;
   logic [31:0] dividend = '0;
   logic [31:0] divisor = '0;
   logic [4:0]  dest_idx = '0;
   logic [31:0] quotient;
   logic        done;
   logic        wr_en;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   logic prev_done = 1'b0;

   typedef struct {
      logic [31:0] q;
      logic        we;
      int          due;
      string       tag;
   } exp_t;
   exp_t sb[$];

   always #2.5 clk = ~clk;

   iter_divider uut (
      .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
      .dividend(dividend), .divisor(divisor), .dest_idx(dest_idx),
      .quotient(quotient), .done(done), .wr_en(wr_en)
   );

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b,
                                         input logic s);
      if (b == 0) return a;
      if (!s) return a / b;
      if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return a;
      return $unsigned($signed(a) / $signed(b));
   endfunction

   task automatic issue(input logic [31:0] a, input logic [31:0] b, input logic s,
                        input logic [4:0] d, input string tag);
      exp_t e;
      @(negedge clk);
      dividend = a; divisor = b; is_signed = s; dest_idx = d; start = 1'b1;
      e.q = model(a, b, s); e.we = (d != 0); e.due = cyc + 1 + 33; e.tag = tag;
      sb.push_back(e);
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic drain();
      while (sb.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (done) begin
            if (sb.size() == 0) begin
               chk(1'b0, "R8 unexpected done", 32'd1, 32'd0);
            end else begin
               exp_t e;
               e = sb.pop_front();
               chk(quotient === e.q, e.tag, quotient, e.q);
               chk(wr_en === e.we, {e.tag, " R6 wr_en"}, {31'd0, wr_en}, {31'd0, e.we});
               chk(cyc == e.due, {e.tag, " R7 latency"}, cyc, e.due);
            end
            chk(!prev_done, "R7 done width", {31'd0, prev_done}, 32'd0);
         end else begin
            chk(!wr_en, "R6 wr_en without done", {31'd0, wr_en}, 32'd0);
         end
         prev_done = done;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(quotient === 32'd0, "R9 reset quotient", quotient, 32'd0);
      chk(done === 1'b0, "R9 reset done", {31'd0, done}, 32'd0);
      chk(wr_en === 1'b0, "R9 reset wr_en", {31'd0, wr_en}, 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      issue(32'd100, 32'd7, 1'b0, 5'd3, "R1 100/7");            drain();
      issue(32'hFFFF_FFFF, 32'd16, 1'b0, 5'd4, "R1 big/16");    drain();
      issue(32'hFFFF_FFFF, 32'd1, 1'b0, 5'd4, "R1 max/1");      drain();
      issue(32'h8000_0000, 32'hFFFF_FFFF, 1'b0, 5'd4, "R1 unsigned min/max"); drain();
      issue(32'd5, 32'd0, 1'b0, 5'd9, "R2 unsigned zero divisor"); drain();
      issue(32'hFFFF_FF9C, 32'd0, 1'b1, 5'd9, "R3 signed zero divisor"); drain();
      issue(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 5'd2, "R4 signed overflow"); drain();
      issue(-32'sd7, 32'd2, 1'b1, 5'd1, "R5 -7/2");             drain();
      issue(32'd7, -32'sd2, 1'b1, 5'd1, "R5 7/-2");             drain();
      issue(-32'sd7, -32'sd2, 1'b1, 5'd1, "R5 -7/-2");          drain();
      issue(32'd7, 32'd2, 1'b1, 5'd1, "R5 7/2");                drain();
      issue(32'd1000, 32'd10, 1'b0, 5'd0, "R6 dest zero");      drain();

      // R8: second start mid-operation must be dropped
      issue(32'd900, 32'd30, 1'b0, 5'd6, "R8 first op kept");
      repeat (5) @(negedge clk);
      dividend = 32'd77; divisor = 32'd0; is_signed = 1'b1; dest_idx = 5'd0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      drain();
      repeat (40) @(negedge clk);

      for (int i = 0; i < 24; i++) begin
         issue($urandom, ($urandom % 4 == 0) ? ($urandom & 32'hFF) : $urandom,
               i[0], 5'($urandom), i[0] ? "R5 random signed" : "R1 random unsigned");
         @(posedge done);
      end
      drain();

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule